// File: doc/BRIEF.md
# UART Receive Byte Buffer with Flow Control and Interrupts

This block sits between a serial receiver and the bus logic that reads received bytes. Each byte the receiver delivers is pushed into a first-in first-out store. The oldest byte is always shown on the read data output, and a one-cycle read strobe removes it. The block drives an active-low ready-to-send line. That line goes high to ask the remote sender to pause when the store is full. A disable input keeps the line low, so the remote end may always send.

Three interrupt-style levels come from the block. The first is high whenever a byte is waiting. The second follows a transmit-ready input from the transmit side. The third is high while the store holds at least half its capacity. A byte that arrives when the store is full and no read happens in the same cycle is dropped, and a sticky overrun flag is raised. The next read strobe clears that flag.

The controller is a three-state machine:
- **Q_EMPTY**: holds nothing.
- **Q_PARTIAL**: holds between one and DEPTH-1 bytes.
- **Q_FULL**: holds DEPTH bytes.

Its transitions are:
- **fill_first**: Q_EMPTY to Q_PARTIAL, on a push.
- **drain_last**: Q_PARTIAL to Q_EMPTY, on a pop without a push at a count of one.
- **fill_last**: Q_PARTIAL to Q_FULL, on a push without a pop at a count of DEPTH-1.
- **drain_first**: Q_FULL to Q_PARTIAL, on a pop without a push.

Every other combination keeps the current state.

Top module: `uart_rx_buffer`

## Requirements
- R1: While rst_n is low and after its release, level is 0 and rx_irq, half_irq, overrun and rts_n are all low.
- R2: While level is non-zero, rd_data shows the oldest stored byte. A read strobe removes that byte at the next rising edge, and bytes leave in the order they were written.
- R3: rx_irq is high exactly when level is non-zero, from the edge that stores the first byte.
- R4: half_irq is high exactly when level is at least DEPTH/2 (8 by default).
- R5: rts_n is high exactly when level equals DEPTH and fc_disable is low. In every other case it is low.
- R6: tx_irq equals tx_ready in the same cycle.
- R7: A write while level equals DEPTH, with no read in the same cycle, is discarded. The stored bytes and level are unchanged, and overrun is high from the next edge.
- R8: overrun stays high until a cycle with rd_en high. At the following edge it returns low.
- R9: A read strobe while level is 0 has no effect. The next stored byte is still the next one read. A write in the same cycle is stored normally.
- R10: A write together with a read while level is non-zero leaves level unchanged. This includes level equal to DEPTH, where the written byte is accepted.
- R11: level reports the number of stored bytes, from 0 to DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Byte-valid strobe from the receiver |
| wr_data | input | 8 | Received byte |
| rd_en | input | 1 | Read strobe from the bus side |
| rd_data | output | 8 | Oldest stored byte |
| tx_ready | input | 1 | Transmit side can take a byte |
| fc_disable | input | 1 | High keeps rts_n low |
| rts_n | output | 1 | Ready-to-send, active low, high when full |
| rx_irq | output | 1 | A byte is available |
| tx_irq | output | 1 | Transmit side can take a byte |
| half_irq | output | 1 | Store is at least half full |
| overrun | output | 1 | Sticky flag for a dropped byte |
| level | output | $clog2(DEPTH)+1 | Number of stored bytes |

## Verification
Write and read strobes act on the next rising edge. level, rd_data, rx_irq, half_irq, rts_n and overrun all reflect the new contents one cycle after the strobe. tx_irq and the effect of fc_disable on rts_n have no delay, because both are combinational.

The bench drives each cycle's inputs shortly after a rising edge. It advances a queue-based model at the next edge, then compares every output two time units later. Each result is therefore checked in the exact cycle it is due.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    typedef enum logic [1:0] {
        Q_EMPTY   = 2'd0,
        Q_PARTIAL = 2'd1,
        Q_FULL    = 2'd2
    } qstate_t;
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wptr;
    logic [AW-1:0]    rptr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr <= '0;
            rptr <= '0;
        end else begin
            if (push) wptr <= wptr + AW'(1);
            if (pop)  rptr <= rptr + AW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem[wptr] <= din;
    end

    assign dout = mem[rptr];
endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          rd_en,
    output logic          push,
    output logic          pop,
    output qstate_t       state,
    output logic [CW-1:0] count,
    output logic          ovr_flag
);
    qstate_t nxt;
    logic    drop;

    // strobe qualification
    always_comb begin
        push = wr_en && ((state != Q_FULL) || rd_en);
        pop  = rd_en && (state != Q_EMPTY);
        drop = wr_en && (state == Q_FULL) && !rd_en;
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            Q_EMPTY: begin
                if (push) nxt = Q_PARTIAL;                        // fill_first
            end
            Q_PARTIAL: begin
                if (push && !pop && count == CW'(DEPTH - 1))
                    nxt = Q_FULL;                                 // fill_last
                else if (pop && !push && count == CW'(1))
                    nxt = Q_EMPTY;                                // drain_last
            end
            Q_FULL: begin
                if (pop && !push) nxt = Q_PARTIAL;                // drain_first
            end
            default: nxt = Q_EMPTY;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= Q_EMPTY;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count    <= '0;
            ovr_flag <= 1'b0;
        end else begin
            if (push && !pop)      count <= count + CW'(1);
            else if (pop && !push) count <= count - CW'(1);
            if (rd_en)     ovr_flag <= 1'b0;
            else if (drop) ovr_flag <= 1'b1;
        end
    end
endmodule

// File: rtl/rxq_flags.sv
module rxq_flags
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW = $clog2(DEPTH) + 1
) (
    input  qstate_t       state,
    input  logic [CW-1:0] count,
    input  logic          fc_disable,
    input  logic          tx_ready,
    output logic          rts_n,
    output logic          rx_irq,
    output logic          tx_irq,
    output logic          half_irq
);
    localparam logic [CW-1:0] HALF = CW'(DEPTH / 2);

    // output decode
    always_comb begin
        rts_n    = 1'b0;
        rx_irq   = 1'b0;
        unique case (state)
            Q_EMPTY:   ;
            Q_PARTIAL: rx_irq = 1'b1;
            Q_FULL: begin
                rx_irq = 1'b1;
                rts_n  = !fc_disable;
            end
            default:   ;
        endcase
        half_irq = (count >= HALF);
        tx_irq   = tx_ready;
    end
endmodule

// File: rtl/uart_rx_buffer.sv
module uart_rx_buffer
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [7:0]    wr_data,
    input  logic          rd_en,
    output logic [7:0]    rd_data,
    input  logic          tx_ready,
    input  logic          fc_disable,
    output logic          rts_n,
    output logic          rx_irq,
    output logic          tx_irq,
    output logic          half_irq,
    output logic          overrun,
    output logic [CW-1:0] level
);
    logic    push;
    logic    pop;
    qstate_t state;

    rxq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .push     (push),
        .pop      (pop),
        .state    (state),
        .count    (level),
        .ovr_flag (overrun)
    );

    rxq_store #(.DEPTH(DEPTH), .WIDTH(8)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .pop   (pop),
        .din   (wr_data),
        .dout  (rd_data)
    );

    rxq_flags #(.DEPTH(DEPTH)) u_flags (
        .state      (state),
        .count      (level),
        .fc_disable (fc_disable),
        .tx_ready   (tx_ready),
        .rts_n      (rts_n),
        .rx_irq     (rx_irq),
        .tx_irq     (tx_irq),
        .half_irq   (half_irq)
    );
endmodule

// File: rtl/rxq_chk.sv
module rxq_chk #(
    parameter int DEPTH = 16,
    localparam int CW = $clog2(DEPTH) + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic          rd_en,
    input logic          fc_disable,
    input logic          tx_ready,
    input logic          rts_n,
    input logic          rx_irq,
    input logic          tx_irq,
    input logic          half_irq,
    input logic          overrun,
    input logic [CW-1:0] level
);
    // R5
    rts_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rts_n |-> (level == CW'(DEPTH) && !fc_disable));

    // R3
    rx_irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq == (level != '0));

    // R4
    half_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        half_irq == (level >= CW'(DEPTH / 2)));

    // R6
    tx_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_irq == tx_ready);

    // R7
    drop_sets_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !rd_en && level == CW'(DEPTH)) |=> (overrun && level == CW'(DEPTH)));

    // R8
    read_clears_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> !overrun);

    // R9
    empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && level == '0) |=> (level == '0));

    // R10
    both_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rd_en && level != '0) |=> (level == $past(level)));

    // R11
    level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        level <= CW'(DEPTH));
endmodule

bind uart_rx_buffer rxq_chk #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .fc_disable (fc_disable),
    .tx_ready   (tx_ready),
    .rts_n      (rts_n),
    .rx_irq     (rx_irq),
    .tx_irq     (tx_irq),
    .half_irq   (half_irq),
    .overrun    (overrun),
    .level      (level)
);

// File: tb/uart_rx_buffer_tb.sv
`timescale 1ns/1ps
module uart_rx_buffer_tb;
    localparam int DEPTH = 16;
    localparam int CW = $clog2(DEPTH) + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [7:0]    wr_data = '0;
    logic          rd_en = 1'b0;
    logic [7:0]    rd_data;
    logic          tx_ready = 1'b0;
    logic          fc_disable = 1'b0;
    logic          rts_n, rx_irq, tx_irq, half_irq, overrun;
    logic [CW-1:0] level;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [7:0] q[$];
    bit ovr_m = 1'b0;

    always #4 clk = ~clk;

    uart_rx_buffer #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .tx_ready(tx_ready),
        .fc_disable(fc_disable), .rts_n(rts_n), .rx_irq(rx_irq),
        .tx_irq(tx_irq), .half_irq(half_irq), .overrun(overrun), .level(level)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk("R11 level", int'(level), q.size());
        chk("R3 rx_irq", int'(rx_irq), int'(q.size() > 0));
        chk("R4 half_irq", int'(half_irq), int'(q.size() >= DEPTH / 2));
        chk("R5 rts_n", int'(rts_n), int'(q.size() == DEPTH && !fc_disable));
        chk("R6 tx_irq", int'(tx_irq), int'(tx_ready));
        chk("R7/R8 overrun", int'(overrun), int'(ovr_m));
        if (q.size() > 0) chk("R2 rd_data", int'(rd_data), int'(q[0]));
    endtask

    // one clock cycle: apply inputs, advance model at edge, compare after
    task automatic step(input bit w, input logic [7:0] d, input bit r,
                        input bit fcd, input bit txr);
        int s;
        bit drop;
        wr_en = w; wr_data = d; rd_en = r; fc_disable = fcd; tx_ready = txr;
        @(posedge clk);
        s = q.size();
        drop = w && s == DEPTH && !r;
        if (r && s > 0) void'(q.pop_front());
        if (w && (s < DEPTH || r)) q.push_back(d);
        if (r) ovr_m = 1'b0;
        else if (drop) ovr_m = 1'b1;
        #2;
        compare_all();
    endtask

    initial begin
        #(150000 * 8);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        #20;
        chk("R1 level in reset", int'(level), 0);
        chk("R1 rx_irq in reset", int'(rx_irq), 0);
        chk("R1 rts_n in reset", int'(rts_n), 0);
        chk("R1 overrun in reset", int'(overrun), 0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #2;
        compare_all();
        chk("R1 half_irq after reset", int'(half_irq), 0);

        // R2, R3: small burst in and out, R6 with tx_ready toggles
        step(1, 8'hA1, 0, 0, 1);
        step(1, 8'hB2, 0, 0, 0);
        step(1, 8'hC3, 0, 0, 1);
        for (int i = 0; i < 3; i++) step(0, 8'h00, 1, 0, i[0]);

        // R9: read on empty, then read+write on empty
        step(0, 8'h00, 1, 0, 0);
        chk("R9 empty read level", int'(level), 0);
        step(1, 8'h5E, 1, 0, 0);
        chk("R9 write with empty read", int'(level), 1);
        step(0, 8'h00, 1, 0, 0);

        // fill to full: R4 at half, R5 at full
        for (int i = 0; i < DEPTH; i++) step(1, 8'(8'h10 + i), 0, 0, 1);
        chk("R5 rts_n high at full", int'(rts_n), 1);

        // R7: write while full is dropped
        step(1, 8'hEE, 0, 0, 1);
        chk("R7 overrun set", int'(overrun), 1);
        chk("R7 oldest kept", int'(rd_data), 8'h10);

        // R5: disable keeps rts_n low
        step(0, 8'h00, 0, 1, 1);
        chk("R5 fc_disable", int'(rts_n), 0);
        step(0, 8'h00, 0, 0, 1);

        // R10 at full, R8 clear by read
        step(1, 8'h77, 1, 0, 0);
        chk("R10 level steady at full", int'(level), DEPTH);
        chk("R8 overrun cleared", int'(overrun), 0);

        // drain fully, R10 mid-level
        for (int i = 0; i < DEPTH - 3; i++) step(0, 8'h00, 1, 0, 0);
        step(1, 8'h99, 1, 0, 1);
        chk("R10 level steady mid", int'(level), 3);
        for (int i = 0; i < 4; i++) step(0, 8'h00, 1, 0, 0);

        // mixed random traffic
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] rv;
            rv = $urandom();
            step(rv[0] | rv[1], rv[15:8], rv[2] & rv[3] & ~rv[4],
                 rv[5] & rv[6], rv[7]);
        end
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] rv;
            rv = $urandom();
            step(rv[0] & rv[1], rv[15:8], rv[2] | rv[3], rv[5] & rv[6], rv[7]);
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule